// File: doc/BRIEF.md
# Bitfield, Extend and Reverse Unit

This block is a purely combinational 32-bit bit-manipulation datapath. A 4-bit operation code selects one of three families of work. The first family handles variable-position fields, each given by a starting bit and a field width: clearing a field, inserting a field, and extracting a field with sign or zero fill. The second family rotates the source right by a whole number of bytes and then sign- or zero-extends a byte, a halfword, or two separate bytes. An optional addend can be added to that result. The third family permutes the source word: it reverses all bits, reverses the bytes of the word, swaps the bytes inside each halfword, or swaps the low two bytes and sign-extends the result.

The surrounding execution stage presents the operands and the operation code and reads back the result in the same cycle. Field positions that cannot fit in the word are flagged on an error output. In that case the destination value passes through unchanged, so the caller can discard or keep it safely. Condition flags and register-file access belong to the surrounding logic.

Top module: `bxr_unit`

## Requirements
- R1: With op_i = 0 (field clear) and a legal field, result_o equals aux_i with bits [lsb_i+width_i-1 : lsb_i] forced to zero and every other bit unchanged.
- R2: With op_i = 1 (field insert) and a legal field, result_o equals aux_i with bits [lsb_i+width_i-1 : lsb_i] replaced by src_i[width_i-1:0].
- R3: With op_i = 2 (signed extract) and a legal field, result_o[width_i-1:0] equals src_i[lsb_i+width_i-1 : lsb_i], and every higher bit equals src_i[lsb_i+width_i-1].
- R4: With op_i = 3 (unsigned extract) and a legal field, the low width_i bits match R3 and every higher bit is zero.
- R5: For op_i 0..3, a field is illegal when width_i = 0 or lsb_i + width_i > 32. An illegal field drives err_o = 1 and result_o = aux_i. Every legal field, and every op_i from 4 to 13, drives err_o = 0.
- R6: For op_i 4 (signed byte), 5 (signed halfword), 7 (unsigned byte) and 8 (unsigned halfword) with add_i = 0, the unit first rotates src_i right by 8*rot_i bits. It then sign- or zero-extends bits [7:0] (byte) or [15:0] (halfword) of the rotated value to 32 bits.
- R7: For op_i 6 (signed dual byte) and 9 (unsigned dual byte) with add_i = 0, the unit rotates src_i as in R6. Rotated bits [7:0] are extended into result_o[15:0], and rotated bits [23:16] are extended into result_o[31:16].
- R8: For op_i 4, 5, 7 and 8 with add_i = 1, result_o is aux_i plus the R6 value, modulo 2^32.
- R9: For op_i 6 and 9 with add_i = 1, each 16-bit half of result_o is the matching half of aux_i plus the matching R7 half, modulo 2^16. No carry passes from the low half to the high half.
- R10: add_i has no effect on result_o or err_o for op_i outside 4..9.
- R11: With op_i = 10, result_o[i] equals src_i[31-i] for every i.
- R12: With op_i = 11, result_o holds the bytes of src_i in reverse order (byte 0 to byte 3 and byte 1 to byte 2). With op_i = 12, the two bytes inside each halfword of src_i are exchanged.
- R13: With op_i = 13, result_o[15:8] = src_i[7:0], result_o[7:0] = src_i[15:8], and result_o[31:16] copies src_i[7].
- R14: op_i values 14 and 15 are unused: they drive err_o = 1 and result_o = aux_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (encodings in the requirements) |
| add_i | input | 1 | Add aux_i to the extended value (extend operations only) |
| src_i | input | 32 | Source operand |
| aux_i | input | 32 | Destination value for field clear/insert; addend for extend-add |
| lsb_i | input | 5 | Lowest bit position of the field |
| width_i | input | 6 | Field width in bits |
| rot_i | input | 2 | Byte rotation count applied before extension |
| result_o | output | 32 | Operation result |
| err_o | output | 1 | Illegal field or unused operation code |

## Verification
The bench targets field edges: width 32 at lsb 0, a one-bit field at bit 31, and a field that ends exactly at bit 31. A mask built with an off-by-one error would clip the field or spill past it. It also targets pairs that overrun by one bit and zero widths. A design with a wrong legality test would either corrupt aux_i or pass an illegal field through without raising err_o. For the dual-byte add, it uses operands whose low half overflows. A word-wide adder would leak that carry into the high half. Every rotation count is exercised with sign bits set, so a misplaced rotate or a fill taken from the wrong bit shows up at once.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    localparam int BXR_W     = 32;
    localparam int BXR_POS_W = $clog2(BXR_W);

    typedef enum logic [3:0] {
        OP_FLD_CLR   = 4'd0,
        OP_FLD_INS   = 4'd1,
        OP_FLD_SX    = 4'd2,
        OP_FLD_UX    = 4'd3,
        OP_EXT_S8    = 4'd4,
        OP_EXT_S16   = 4'd5,
        OP_EXT_S8X2  = 4'd6,
        OP_EXT_U8    = 4'd7,
        OP_EXT_U16   = 4'd8,
        OP_EXT_U8X2  = 4'd9,
        OP_BIT_REV   = 4'd10,
        OP_BYTE_REV  = 4'd11,
        OP_HALF_SWAP = 4'd12,
        OP_LOW_SWAPS = 4'd13
    } bxr_op_e;

    typedef enum logic [1:0] {
        GRP_FIELD,
        GRP_EXT,
        GRP_PERM,
        GRP_NONE
    } bxr_grp_e;

    typedef struct packed {
        logic is_signed;
        logic half;
        logic dual;
    } ext_ctl_t;

    function automatic bxr_grp_e op_group(input logic [3:0] op);
        if (op <= 4'd3)       return GRP_FIELD;
        else if (op <= 4'd9)  return GRP_EXT;
        else if (op <= 4'd13) return GRP_PERM;
        else                  return GRP_NONE;
    endfunction

    function automatic ext_ctl_t ext_decode(input logic [3:0] op);
        ext_ctl_t c;
        c.is_signed = (op == OP_EXT_S8) || (op == OP_EXT_S16) || (op == OP_EXT_S8X2);
        c.half      = (op == OP_EXT_S16) || (op == OP_EXT_U16);
        c.dual      = (op == OP_EXT_S8X2) || (op == OP_EXT_U8X2);
        return c;
    endfunction

endpackage

// File: rtl/bxr_field.sv
module bxr_field
    import bxr_pkg::*;
#(
    parameter int DW = BXR_W,
    localparam int LW = $clog2(DW)
) (
    input  logic [1:0]    sub_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] aux_i,
    input  logic [LW-1:0] lsb_i,
    input  logic [LW:0]   width_i,
    output logic [DW-1:0] res_o,
    output logic          bad_o
);

    logic [LW+1:0] span;
    logic [DW-1:0] low_mask;
    logic [DW-1:0] fld_mask;
    logic [DW-1:0] shifted;
    logic          top_bit;

    always_comb begin
        span     = (LW+2)'(lsb_i) + (LW+2)'(width_i);
        bad_o    = (width_i == '0) || (span > (LW+2)'(DW));
        low_mask = (width_i >= (LW+1)'(DW)) ? '1
                 : ((DW'(1) << width_i) - DW'(1));
        fld_mask = low_mask << lsb_i;
        shifted  = src_i >> lsb_i;
        top_bit  = |(shifted & low_mask & ~(low_mask >> 1));

        unique case (sub_i)
            2'd0:    res_o = aux_i & ~fld_mask;
            2'd1:    res_o = (aux_i & ~fld_mask) | ((src_i & low_mask) << lsb_i);
            2'd2:    res_o = (shifted & low_mask) | (top_bit ? ~low_mask : '0);
            default: res_o = shifted & low_mask;
        endcase
        if (bad_o) res_o = aux_i;
    end

    always_comb begin
        if (!bad_o && sub_i == 2'd0) begin
            a_r1_outside_kept: assert ((res_o & ~fld_mask) == (aux_i & ~fld_mask))
                else $error("R1 clear touched bits outside the field");
        end
        if (!bad_o && sub_i == 2'd3) begin
            a_r4_upper_zero: assert ((res_o & ~low_mask) == '0)
                else $error("R4 unsigned extract left upper bits set");
        end
    end

endmodule

// File: rtl/bxr_extend.sv
module bxr_extend
    import bxr_pkg::*;
#(
    parameter int DW = BXR_W,
    localparam int LANES = DW / 16
) (
    input  ext_ctl_t      ctl_i,
    input  logic [1:0]    rot_i,
    input  logic          add_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] aux_i,
    output logic [DW-1:0] res_o
);

    logic [2*DW-1:0] doubled;
    logic [DW-1:0]   rotated;
    logic [DW-1:0]   word_ext;
    logic [DW-1:0]   single_res;
    logic [DW-1:0]   dual_res;

    assign doubled = {src_i, src_i} >> {rot_i, 3'b000};
    assign rotated = doubled[DW-1:0];

    assign word_ext = ctl_i.half
        ? {{(DW-16){ctl_i.is_signed & rotated[15]}}, rotated[15:0]}
        : {{(DW-8){ctl_i.is_signed & rotated[7]}},  rotated[7:0]};

    assign single_res = add_i ? (aux_i + word_ext) : word_ext;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [7:0]  lane_byte;
        logic [15:0] lane_ext;
        assign lane_byte = rotated[16*k +: 8];
        assign lane_ext  = {{8{ctl_i.is_signed & lane_byte[7]}}, lane_byte};
        assign dual_res[16*k +: 16] = add_i ? (aux_i[16*k +: 16] + lane_ext) : lane_ext;
    end

    assign res_o = ctl_i.dual ? dual_res : single_res;

    always_comb begin
        if (ctl_i.dual && !add_i) begin
            a_r7_low_lane_fill: assert (res_o[15:8] == {8{ctl_i.is_signed & res_o[7]}})
                else $error("R7 low lane fill does not follow its byte");
        end
    end

endmodule

// File: rtl/bxr_permute.sv
module bxr_permute
    import bxr_pkg::*;
#(
    parameter int DW = BXR_W,
    localparam int NB = DW / 8
) (
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] src_i,
    output logic [DW-1:0] res_o
);

    logic [DW-1:0] bit_rev;
    logic [DW-1:0] byte_rev;
    logic [DW-1:0] half_swap;
    logic [DW-1:0] low_swap;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign bit_rev[i] = src_i[DW-1-i];
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_rev[8*b +: 8]  = src_i[8*(NB-1-b) +: 8];
        assign half_swap[8*b +: 8] = src_i[8*(b ^ 1) +: 8];
    end

    assign low_swap = {{(DW-16){src_i[7]}}, src_i[7:0], src_i[15:8]};

    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = bit_rev;
            2'd1:    res_o = byte_rev;
            2'd2:    res_o = half_swap;
            default: res_o = low_swap;
        endcase
    end

    always_comb begin
        if (sel_i == 2'd3) begin
            a_r13_upper_fill: assert (res_o[DW-1:16] == {(DW-16){res_o[15]}})
                else $error("R13 upper half not a copy of the sign");
        end
        if (sel_i == 2'd1) begin
            a_r12_end_bytes: assert (res_o[7:0] == src_i[DW-1:DW-8])
                else $error("R12 byte order wrong");
        end
    end

endmodule

// File: rtl/bxr_unit.sv
module bxr_unit
    import bxr_pkg::*;
#(
    parameter int DATA_W = BXR_W
) (
    input  logic [3:0]           op_i,
    input  logic                 add_i,
    input  logic [DATA_W-1:0]    src_i,
    input  logic [DATA_W-1:0]    aux_i,
    input  logic [BXR_POS_W-1:0] lsb_i,
    input  logic [BXR_POS_W:0]   width_i,
    input  logic [1:0]           rot_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 err_o
);

    bxr_grp_e       grp;
    ext_ctl_t       ext_ctl;
    logic [DATA_W-1:0] fld_res, ext_res, perm_res;
    logic              fld_bad;
    logic [1:0]        perm_sel;

    assign grp      = op_group(op_i);
    assign ext_ctl  = ext_decode(op_i);
    assign perm_sel = 2'(op_i - 4'd10);

    bxr_field #(.DW(DATA_W)) u_field (
        .sub_i   (op_i[1:0]),
        .src_i   (src_i),
        .aux_i   (aux_i),
        .lsb_i   (lsb_i),
        .width_i (width_i),
        .res_o   (fld_res),
        .bad_o   (fld_bad)
    );

    bxr_extend #(.DW(DATA_W)) u_extend (
        .ctl_i (ext_ctl),
        .rot_i (rot_i),
        .add_i (add_i),
        .src_i (src_i),
        .aux_i (aux_i),
        .res_o (ext_res)
    );

    bxr_permute #(.DW(DATA_W)) u_permute (
        .sel_i (perm_sel),
        .src_i (src_i),
        .res_o (perm_res)
    );

    always_comb begin
        unique case (grp)
            GRP_FIELD: begin result_o = fld_res;  err_o = fld_bad; end
            GRP_EXT:   begin result_o = ext_res;  err_o = 1'b0;    end
            GRP_PERM:  begin result_o = perm_res; err_o = 1'b0;    end
            default:   begin result_o = aux_i;    err_o = 1'b1;    end
        endcase
    end

    always_comb begin
        if (err_o) begin
            a_r5_err_passes_aux: assert (result_o == aux_i)
                else $error("R5 error raised but result differs from aux");
        end
        if (op_i >= 4'd14) begin
            a_r14_unused_flagged: assert (err_o)
                else $error("R14 unused code not flagged");
        end
    end

endmodule

// File: tb/bxr_unit_test.sv
`timescale 1ns/1ps
module bxr_unit_test;

    logic        clk = 1'b0;
    logic [3:0]  op;
    logic        add;
    logic [31:0] src, aux;
    logic [4:0]  lsb;
    logic [5:0]  width;
    logic [1:0]  rot;
    logic [31:0] result;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bxr_unit uut (
        .op_i(op), .add_i(add), .src_i(src), .aux_i(aux),
        .lsb_i(lsb), .width_i(width), .rot_i(rot),
        .result_o(result), .err_o(err)
    );

    function automatic string tag_of(input logic [3:0] o, input bit a,
                                     input int w, input int l);
        if (o <= 3 && (w == 0 || l + w > 32)) return "R5";
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5, 4'd7, 4'd8: return a ? "R8" : "R6";
            4'd6, 4'd9: return a ? "R9" : "R7";
            4'd10: return "R11";
            4'd11, 4'd12: return "R12";
            4'd13: return "R13";
            default: return "R14";
        endcase
    endfunction

    task automatic model(input logic [3:0] o, input bit a,
                         input logic [31:0] s, input logic [31:0] x,
                         input int l, input int w, input int r,
                         output logic [31:0] e, output bit ee);
        logic [31:0] rt;
        int v;
        e = 32'h0; ee = 1'b0;
        for (int i = 0; i < 32; i++) rt[i] = s[(i + 8*r) % 32];
        if (o <= 3 && (w == 0 || l + w > 32)) begin
            e = x; ee = 1'b1;
        end else begin
            case (o)
                4'd0: begin e = x; for (int i = l; i < l + w; i++) e[i] = 1'b0; end
                4'd1: begin e = x; for (int i = 0; i < w; i++) e[l+i] = s[i]; end
                4'd2, 4'd3: begin
                    for (int i = 0; i < 32; i++)
                        e[i] = (i < w) ? s[l+i] : ((o == 4'd2) ? s[l+w-1] : 1'b0);
                end
                4'd4, 4'd5, 4'd7, 4'd8: begin
                    if (o == 4'd4)      v = $signed(rt[7:0]);
                    else if (o == 4'd5) v = $signed(rt[15:0]);
                    else if (o == 4'd7) v = int'(rt[7:0]);
                    else                v = int'(rt[15:0]);
                    e = 32'(v);
                    if (a) e = e + x;
                end
                4'd6, 4'd9: begin
                    logic [15:0] lo, hi;
                    lo = (o == 4'd6) ? 16'($signed(rt[7:0]))   : {8'h0, rt[7:0]};
                    hi = (o == 4'd6) ? 16'($signed(rt[23:16])) : {8'h0, rt[23:16]};
                    if (a) begin lo = lo + x[15:0]; hi = hi + x[31:16]; end
                    e = {hi, lo};
                end
                4'd10: for (int i = 0; i < 32; i++) e[i] = s[31-i];
                4'd11: e = {s[7:0], s[15:8], s[23:16], s[31:24]};
                4'd12: e = {s[23:16], s[31:24], s[7:0], s[15:8]};
                4'd13: e = {{16{s[7]}}, s[7:0], s[15:8]};
                default: begin e = x; ee = 1'b1; end
            endcase
        end
    endtask

    task automatic run(input logic [3:0] o, input bit a, input logic [31:0] s,
                       input logic [31:0] x, input int l, input int w, input int r,
                       input string tag);
        logic [31:0] e; bit ee;
        @(posedge clk); #1;
        op = o; add = a; src = s; aux = x;
        lsb = 5'(l); width = 6'(w); rot = 2'(r);
        @(negedge clk);
        model(o, a, s, x, l, w, r, e, ee);
        checks++;
        if (result !== e || err !== ee) begin
            errors++;
            $display("FAIL %s op=%0d: result=%h err=%0b expected result=%h err=%0b",
                     tag, o, result, err, e, ee);
        end
    endtask

    initial begin
        op = 0; add = 0; src = 0; aux = 0; lsb = 0; width = 0; rot = 0;
        // initial state: all-zero inputs are an illegal field (R5)
        run(4'd0, 0, 32'h0, 32'h0, 0, 0, 0, "R5");
        // R1 clear
        run(4'd0, 0, 32'h0, 32'hFFFF_FFFF, 4, 8, 0, "R1");
        run(4'd0, 0, 32'h0, 32'hDEAD_BEEF, 0, 32, 0, "R1");
        // R2 insert, field touching bit 31
        run(4'd1, 0, 32'h0000_00A5, 32'h1234_5678, 24, 8, 0, "R2");
        run(4'd1, 0, 32'hFFFF_FFFF, 32'h0, 31, 1, 0, "R2");
        // R3 signed and R4 unsigned extract
        run(4'd2, 0, 32'h0000_0F00, 32'h0, 8, 4, 0, "R3");
        run(4'd2, 0, 32'h8000_0000, 32'h0, 31, 1, 0, "R3");
        run(4'd3, 0, 32'hF000_0F00, 32'h0, 8, 4, 0, "R4");
        run(4'd3, 0, 32'h8765_4321, 32'h0, 0, 32, 0, "R4");
        // R5 illegal fields
        run(4'd1, 0, 32'hFFFF_FFFF, 32'hCAFE_F00D, 1, 32, 0, "R5");
        run(4'd2, 0, 32'hFFFF_FFFF, 32'h0BAD_CAFE, 20, 13, 0, "R5");
        run(4'd3, 0, 32'hFFFF_FFFF, 32'h1357_9BDF, 5, 0, 0, "R5");
        // R6 all rotations with sign bits set
        for (int r = 0; r < 4; r++) begin
            run(4'd4, 0, 32'h80C0_F0FF, 32'h0, 0, 0, r, "R6");
            run(4'd5, 0, 32'h80C0_F0FF, 32'h0, 0, 0, r, "R6");
            run(4'd7, 0, 32'h80C0_F0FF, 32'h0, 0, 0, r, "R6");
            run(4'd8, 0, 32'h80C0_F0FF, 32'h0, 0, 0, r, "R6");
        end
        // R7 dual byte
        run(4'd6, 0, 32'h0080_007F, 32'h0, 0, 0, 0, "R7");
        run(4'd9, 0, 32'h8000_8000, 32'h0, 0, 0, 1, "R7");
        // R8 wrap, R9 no carry between halves
        run(4'd7, 1, 32'h0000_00FF, 32'hFFFF_FFF0, 0, 0, 0, "R8");
        run(4'd5, 1, 32'h0000_8000, 32'h0000_0001, 0, 0, 0, "R8");
        run(4'd9, 1, 32'h0000_00FF, 32'h0000_FFFF, 0, 0, 0, "R9");
        run(4'd6, 1, 32'h00FF_00FF, 32'h0001_0000, 0, 0, 0, "R9");
        // R10 add_i ignored elsewhere
        run(4'd11, 1, 32'h0102_0304, 32'hFFFF_FFFF, 0, 0, 0, "R10");
        run(4'd0, 1, 32'h0, 32'hFFFF_FFFF, 0, 4, 0, "R10");
        // R11..R13 permutes
        run(4'd10, 0, 32'h0000_0001, 32'h0, 0, 0, 0, "R11");
        run(4'd10, 0, 32'h1234_5678, 32'h0, 0, 0, 0, "R11");
        run(4'd11, 0, 32'h1122_3344, 32'h0, 0, 0, 0, "R12");
        run(4'd12, 0, 32'h1122_3344, 32'h0, 0, 0, 0, "R12");
        run(4'd13, 0, 32'h0000_1280, 32'h0, 0, 0, 0, "R13");
        run(4'd13, 0, 32'hFFFF_807F, 32'h0, 0, 0, 0, "R13");
        // R14 unused codes
        run(4'd14, 0, 32'h1, 32'hA5A5_5A5A, 0, 0, 0, "R14");
        run(4'd15, 1, 32'h1, 32'h5A5A_A5A5, 0, 0, 0, "R14");
        // random sweep against the model
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] o; bit a; int l, w, r;
            o = 4'($urandom_range(0, 15));
            a = 1'($urandom_range(0, 1));
            l = $urandom_range(0, 31);
            w = $urandom_range(0, 40);
            r = $urandom_range(0, 3);
            run(o, a, $urandom, $urandom, l, w, r, tag_of(o, a, w, l));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule